// File: doc/BRIEF.md
# Interrupt controller register port with shadow readback

This block is the register side of an 8259-style interrupt controller for one controller. A host writes and reads bytes on two port addresses: the even port and the odd port. Writes to the even port carry the first init word or one of two operation command words; writes to the odd port carry the rest of the init sequence and, once that sequence is done, the interrupt mask. The block keeps request, in-service and mask registers. It also latches the vector base, the fourth init word and the most recent operation command words.

Priority resolution, the acknowledge cycle and cascading are handled elsewhere. A neighbour sets request bits through `req_in` and moves requests into service through `svc_set`. One cascade input, `slave_isr_any`, is folded into the in-service readback when the block is built as the AT master.

A shadow mode can be switched on from outside. In that mode the two ports no longer return live status. Instead they return packed copies of configuration bits: selected bits of the latched command and init words, and the upper five bits of the vector base. Reads return data one cycle after the read strobe.

Top module: `pic_shadow_ctl`

## Requirements
- R1: After reset `rdata` is 0xFF, the request, in-service and mask registers are 0, read-select is 0 and shadow mode is off.
- R2: An even-port write with data bit 4 set is the first init word. It clears the in-service register, the mask and read-select. The next odd-port write loads the vector base, the one after that loads the fourth init word, and later odd-port writes load the mask.
- R3: An even-port write with bits 4 and 3 clear is an OCW2 and is latched whole. When bits 7:5 are 011, the in-service bit chosen by bits 2:0 is cleared, and this clear wins over a simultaneous `svc_set`. Other values of bits 7:5 leave the in-service register unchanged.
- R4: An even-port write with bit 4 clear and bit 3 set is an OCW3 and is latched whole. When bit 1 is set, read-select takes bit 0. When bit 1 is clear, read-select is unchanged.
- R5: With shadow mode off, an odd-port (address 1) read returns the mask. An even-port (address 0) read returns the in-service register when read-select is 1, and the request register otherwise.
- R6: With parameter AT_MASTER set, an in-service readback has bit 2 forced to 1 whenever `slave_isr_any` is 1.
- R7: With shadow mode on, an even-port read returns {3'b000, OCW3[5], OCW2[7], ICW4[4], ICW4[1], ICW4[3]}.
- R8: With shadow mode on, an odd-port read returns {3'b000, vector[7:3]}.
- R9: Shadow mode is cleared by reset and by the first init word. Otherwise it takes `shadow_val` on a cycle with `shadow_wr` high.
- R10: A read of any address other than 0 or 1 returns 0xFF.
- R11: Reads change no register; repeated reads return the same value.
- R12: Each cycle, request bits set by `req_in` are ORed into the request register. Bits set in `svc_set` are cleared from the request register and set in the in-service register.
- R13: `rdata` is loaded on the clock edge where `rd_en` is high and holds its value in every cycle where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Port address: 0 even, 1 odd |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| req_in | input | 8 | Request bits to set |
| svc_set | input | 8 | Requests entering service |
| slave_isr_any | input | 1 | Slave has an interrupt in service |
| shadow_wr | input | 1 | Load shadow enable |
| shadow_val | input | 1 | New shadow enable value |

## Verification
The in-module assertions check the following on every cycle:
- the write decode strobes are mutually exclusive;
- a specific end-of-interrupt clears its bit;
- an OCW3 without bit 1 keeps read-select;
- the first init word arms the sequence and drops shadow mode;
- undecoded reads give 0xFF;
- shadow odd reads keep the upper bits zero;
- `rdata` holds when no read is issued.

The bench's scenarios are needed for the rest:
- the bit packing in shadow mode against values written earlier;
- the order of the init sequence;
- the cascade bit merge;
- the movement of requests into service;
- the lack of side effects from reads.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DW = 8;
  localparam int IDX_W = $clog2(DW);
  localparam int VEC_SHIFT = 3;
  localparam logic [2:0] SEOI_CODE = 3'b011;

  typedef enum logic [1:0] {
    SEQ_READY = 2'd0,
    SEQ_VEC   = 2'd1,
    SEQ_ICW4  = 2'd2
  } seq_e;
endpackage

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
  import pic_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic              icw1_wr,
  output logic              ocw2_wr,
  output logic              ocw3_wr,
  output logic              odd_wr
);
  logic even_hit, odd_hit;

  always_comb begin
    even_hit = wr_en && (addr == ADDR_W'(0));
    odd_hit  = wr_en && (addr == ADDR_W'(1));
    icw1_wr  = even_hit && wdata[4];
    ocw2_wr  = even_hit && !wdata[4] && !wdata[3];
    ocw3_wr  = even_hit && !wdata[4] && wdata[3];
    odd_wr   = odd_hit;
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({icw1_wr, ocw2_wr, ocw3_wr, odd_wr}));
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          icw1_wr,
  input  logic          ocw2_wr,
  input  logic          ocw3_wr,
  input  logic          odd_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] req_in,
  input  logic [DW-1:0] svc_set,
  input  logic          shadow_wr,
  input  logic          shadow_val,
  output logic [DW-1:0] irr_o,
  output logic [DW-1:0] isr_o,
  output logic [DW-1:0] imr_o,
  output logic [DW-1:0] vec_o,
  output logic [DW-1:0] icw4_o,
  output logic [DW-1:0] ocw2_o,
  output logic [DW-1:0] ocw3_o,
  output logic          rd_sel_o,
  output logic          shadow_o
);
  logic [DW-1:0] irr_q, irr_d, isr_q, isr_d, imr_q, imr_d;
  logic [DW-1:0] vec_q, vec_d, icw4_q, icw4_d, ocw2_q, ocw2_d, ocw3_q, ocw3_d;
  logic          rd_sel_q, rd_sel_d, shadow_q, shadow_d;
  seq_e          seq_q, seq_d;
  logic          seoi;

  always_comb begin
    irr_d    = (irr_q | req_in) & ~svc_set;
    isr_d    = isr_q | svc_set;
    imr_d    = imr_q;
    vec_d    = vec_q;
    icw4_d   = icw4_q;
    ocw2_d   = ocw2_q;
    ocw3_d   = ocw3_q;
    rd_sel_d = rd_sel_q;
    shadow_d = shadow_q;
    seq_d    = seq_q;
    seoi     = ocw2_wr && (wdata[7:5] == SEOI_CODE);

    if (shadow_wr) shadow_d = shadow_val;
    if (ocw2_wr) ocw2_d = wdata;
    if (seoi) isr_d[wdata[IDX_W-1:0]] = 1'b0;
    if (ocw3_wr) begin
      ocw3_d = wdata;
      if (wdata[1]) rd_sel_d = wdata[0];
    end
    if (odd_wr) begin
      case (seq_q)
        SEQ_VEC: begin
          vec_d = wdata;
          seq_d = SEQ_ICW4;
        end
        SEQ_ICW4: begin
          icw4_d = wdata;
          seq_d  = SEQ_READY;
        end
        default: imr_d = wdata;
      endcase
    end
    if (icw1_wr) begin
      isr_d    = '0;
      imr_d    = '0;
      rd_sel_d = 1'b0;
      shadow_d = 1'b0;
      seq_d    = SEQ_VEC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q    <= '0;
      isr_q    <= '0;
      imr_q    <= '0;
      vec_q    <= '0;
      icw4_q   <= '0;
      ocw2_q   <= '0;
      ocw3_q   <= '0;
      rd_sel_q <= 1'b0;
      shadow_q <= 1'b0;
      seq_q    <= SEQ_READY;
    end else begin
      irr_q    <= irr_d;
      isr_q    <= isr_d;
      imr_q    <= imr_d;
      vec_q    <= vec_d;
      icw4_q   <= icw4_d;
      ocw2_q   <= ocw2_d;
      ocw3_q   <= ocw3_d;
      rd_sel_q <= rd_sel_d;
      shadow_q <= shadow_d;
      seq_q    <= seq_d;
    end
  end

  assign irr_o    = irr_q;
  assign isr_o    = isr_q;
  assign imr_o    = imr_q;
  assign vec_o    = vec_q;
  assign icw4_o   = icw4_q;
  assign ocw2_o   = ocw2_q;
  assign ocw3_o   = ocw3_q;
  assign rd_sel_o = rd_sel_q;
  assign shadow_o = shadow_q;

  // R3
  seoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ocw2_wr && wdata[7:5] == SEOI_CODE) |=> !isr_q[$past(wdata[IDX_W-1:0])]);
  // R4
  rdsel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ocw3_wr && !wdata[1]) |=> (rd_sel_q == $past(rd_sel_q)));
  // R9
  shadow_init_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    icw1_wr |=> !shadow_q);
  // R2
  seq_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    icw1_wr |=> (seq_q == SEQ_VEC));
endmodule

// File: rtl/pic_rd_port.sv
module pic_rd_port
  import pic_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter bit AT_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     irr,
  input  logic [DW-1:0]     isr,
  input  logic [DW-1:0]     imr,
  input  logic [DW-1:0]     vec,
  input  logic [DW-1:0]     icw4,
  input  logic [DW-1:0]     ocw2,
  input  logic [DW-1:0]     ocw3,
  input  logic              rd_sel,
  input  logic              shadow,
  input  logic              slave_isr_any,
  output logic [DW-1:0]     rdata
);
  localparam logic [DW-1:0] CASCADE_BIT = DW'(1) << 2;

  logic [DW-1:0] cascade_or, rd_val, rdata_q;

  generate
    if (AT_MASTER) begin : g_master
      assign cascade_or = slave_isr_any ? CASCADE_BIT : '0;
    end else begin : g_plain
      assign cascade_or = '0;
    end
  endgenerate

  always_comb begin
    rd_val = '1;
    if (addr == ADDR_W'(0)) begin
      if (shadow)      rd_val = {3'b000, ocw3[5], ocw2[7], icw4[4], icw4[1], icw4[3]};
      else if (rd_sel) rd_val = isr | cascade_or;
      else             rd_val = irr;
    end else if (addr == ADDR_W'(1)) begin
      rd_val = shadow ? (vec >> VEC_SHIFT) : imr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '1;
    else if (rd_en) rdata_q <= rd_val;
  end

  assign rdata = rdata_q;

  // R10
  undecoded_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > ADDR_W'(1)) |=> (rdata == '1));
  // R8
  shadow_vec_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && shadow && addr == ADDR_W'(1)) |=> (rdata[DW-1:DW-VEC_SHIFT] == '0));
  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/pic_shadow_ctl.sv
module pic_shadow_ctl
  import pic_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter bit AT_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     req_in,
  input  logic [DW-1:0]     svc_set,
  input  logic              slave_isr_any,
  input  logic              shadow_wr,
  input  logic              shadow_val
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic icw1_wr, ocw2_wr, ocw3_wr, odd_wr;
  logic [DW-1:0] irr, isr, imr, vec, icw4, ocw2, ocw3;
  logic rd_sel, shadow;

  pic_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .icw1_wr(icw1_wr), .ocw2_wr(ocw2_wr), .ocw3_wr(ocw3_wr), .odd_wr(odd_wr)
  );

  pic_core u_core (
    .clk(clk), .rst_n(rst_int_n),
    .icw1_wr(icw1_wr), .ocw2_wr(ocw2_wr), .ocw3_wr(ocw3_wr), .odd_wr(odd_wr),
    .wdata(wdata), .req_in(req_in), .svc_set(svc_set),
    .shadow_wr(shadow_wr), .shadow_val(shadow_val),
    .irr_o(irr), .isr_o(isr), .imr_o(imr), .vec_o(vec), .icw4_o(icw4),
    .ocw2_o(ocw2), .ocw3_o(ocw3), .rd_sel_o(rd_sel), .shadow_o(shadow)
  );

  pic_rd_port #(.ADDR_W(ADDR_W), .AT_MASTER(AT_MASTER)) u_rd (
    .clk(clk), .rst_n(rst_int_n), .rd_en(rd_en), .addr(addr),
    .irr(irr), .isr(isr), .imr(imr), .vec(vec), .icw4(icw4),
    .ocw2(ocw2), .ocw3(ocw3), .rd_sel(rd_sel), .shadow(shadow),
    .slave_isr_any(slave_isr_any), .rdata(rdata)
  );
endmodule

// File: tb/tb_pic_shadow_ctl.sv
module tb_pic_shadow_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, req_in = '0, svc_set = '0;
  logic [7:0] rdata;
  logic       slave_isr_any = 1'b0, shadow_wr = 1'b0, shadow_val = 1'b0;

  always #5 clk = ~clk;

  pic_shadow_ctl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .req_in(req_in), .svc_set(svc_set),
    .slave_isr_any(slave_isr_any), .shadow_wr(shadow_wr), .shadow_val(shadow_val)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       mon_pending = 1'b0;

  logic [7:0] m_irr, m_isr, m_mask, m_vec, m_icw4, m_ocw2, m_ocw3;
  logic       m_rs, m_sh;
  int         m_seq;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_irr = 0; m_isr = 0; m_mask = 0; m_vec = 0; m_icw4 = 0;
    m_ocw2 = 0; m_ocw3 = 0; m_rs = 0; m_sh = 0; m_seq = 0;
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    if (a == 2'd0) begin
      if (m_sh)      return {3'b000, m_ocw3[5], m_ocw2[7], m_icw4[4], m_icw4[1], m_icw4[3]};
      else if (m_rs) return m_isr | (slave_isr_any ? 8'h04 : 8'h00);
      else           return m_irr;
    end else if (a == 2'd1) begin
      return m_sh ? {3'b000, m_vec[7:3]} : m_mask;
    end
    return 8'hFF;
  endfunction

  // driver: write
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    if (a == 2'd0 && d[4]) begin
      m_isr = 0; m_mask = 0; m_rs = 0; m_sh = 0; m_seq = 1;
    end else if (a == 2'd0 && !d[3]) begin
      m_ocw2 = d;
      if (d[7:5] == 3'b011) m_isr[d[2:0]] = 1'b0;
    end else if (a == 2'd0) begin
      m_ocw3 = d;
      if (d[1]) m_rs = d[0];
    end else if (a == 2'd1) begin
      if (m_seq == 1) begin m_vec = d; m_seq = 2; end
      else if (m_seq == 2) begin m_icw4 = d; m_seq = 0; end
      else m_mask = d;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: read, pushes expected value into scoreboard
  task automatic rd(input logic [1:0] a, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp_rd(a));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_req(input logic [7:0] r, input logic [7:0] s);
    @(negedge clk);
    req_in = r; svc_set = s;
    m_irr = (m_irr | r) & ~s;
    m_isr = m_isr | s;
    @(negedge clk);
    req_in = '0; svc_set = '0;
  endtask

  task automatic set_shadow(input logic v);
    @(negedge clk);
    shadow_wr = 1'b1; shadow_val = v; m_sh = v;
    @(negedge clk);
    shadow_wr = 1'b0;
  endtask

  // monitor
  always @(posedge clk) mon_pending <= rd_en;
  always @(negedge clk) begin
    if (mon_pending) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R13: read with empty scoreboard, actual %02h expected none", rdata);
      end else begin
        check(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    model_reset();
    repeat (3) @(negedge clk);
    check(rdata, 8'hFF, "R1 rdata in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rdata, 8'hFF, "R1 rdata after reset");
    rd(2'd0, "R1 request reg after reset");
    rd(2'd1, "R1 mask after reset");

    // init sequence
    wr(2'd0, 8'h11);
    wr(2'd1, 8'h48);
    wr(2'd1, 8'h1A);
    wr(2'd1, 8'hF0);
    rd(2'd1, "R2 R5 mask after init");
    wr(2'd1, 8'h3C);
    rd(2'd1, "R2 mask rewrite");

    // requests and service
    pulse_req(8'h0C, 8'h00);
    rd(2'd0, "R12 R5 request reg");
    pulse_req(8'h00, 8'h04);
    rd(2'd0, "R12 request cleared on service");
    pulse_req(8'h00, 8'h01);
    wr(2'd0, 8'h0B);
    rd(2'd0, "R4 R5 in-service read");
    wr(2'd0, 8'h62);
    rd(2'd0, "R3 specific EOI clears bit 2");
    @(negedge clk); slave_isr_any = 1'b1;
    rd(2'd0, "R6 cascade bit merged");
    @(negedge clk); slave_isr_any = 1'b0;
    wr(2'd0, 8'h20);
    rd(2'd0, "R3 non-specific code leaves in-service");
    wr(2'd0, 8'h08);
    rd(2'd0, "R4 read-select kept when bit1 clear");
    wr(2'd0, 8'h0A);
    rd(2'd0, "R4 read-select back to request");

    // no side effects of reads
    rd(2'd0, "R11 repeat read 1");
    rd(2'd0, "R11 repeat read 2");
    rd(2'd1, "R11 mask read");
    rd(2'd0, "R11 repeat read 3");

    // read data hold
    held = exp_rd(2'd0);
    pulse_req(8'h80, 8'h00);
    repeat (2) @(negedge clk);
    check(rdata, held, "R13 rdata holds without read");

    // shadow mode
    set_shadow(1'b1);
    rd(2'd0, "R7 shadow packing from init word");
    rd(2'd1, "R8 shadow vector");
    wr(2'd0, 8'h28);
    wr(2'd0, 8'hE0);
    rd(2'd0, "R7 shadow packing all set");
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h60);
    rd(2'd0, "R7 shadow packing command bits clear");
    rd(2'd2, "R10 undecoded address 2");
    rd(2'd3, "R10 undecoded address 3");
    set_shadow(1'b0);
    rd(2'd1, "R9 shadow off by enable");
    set_shadow(1'b1);
    rd(2'd1, "R9 shadow on again");

    // init word forces shadow off
    wr(2'd0, 8'h13);
    rd(2'd1, "R9 shadow off after init word");
    wr(2'd1, 8'hF8);
    wr(2'd1, 8'h00);
    set_shadow(1'b1);
    rd(2'd1, "R8 new vector in shadow");
    rd(2'd0, "R7 packing after new init word");

    // reset forces shadow off
    @(negedge clk); rst_n = 1'b0; model_reset();
    @(negedge clk);
    check(rdata, 8'hFF, "R1 rdata in second reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd1, "R9 shadow off after reset");
    rd(2'd0, "R1 request reg after second reset");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R13: actual %0d pending reads expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule